// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block produces the bit clock for a synchronous serial port that runs as a master. The peripheral clock passes through two divider stages. The first is a programmable prescaler that accepts only even divisors. The second is a rate divider set from an 8-bit control input. The result is a bit-clock level output plus two strobes, each one peripheral-clock cycle wide, that mark the rising and falling edges. A shift register uses these strobes to launch and capture data.

The prescale value is held in a small register with its own write and read port. The register clears to zero at reset. Zero cannot be used as a divisor, so no clock runs until software writes a legal value, and a configuration-error flag shows this condition while master mode is selected. When the port is a slave, or is disabled, the generator stays idle and drives the bit clock at the level chosen by a polarity input. A separate comparator reports whether an externally measured ratio between the peripheral clock and an incoming bit clock is slow enough for slave operation.

A full bit period lasts prescale × (rate + 1) peripheral clocks, and each level lasts half of that. New prescale or rate values are adopted only when a period completes, or while the generator is idle. A running clock therefore never produces a shortened half-period.

Top module: `spi_bitclk_gen`

## Requirements
- R1: A write to the prescale register stores the written byte with bit 0 forced to 0. The read port returns the stored value, so bit 0 always reads 0 (writing 0x05 reads back 0x04, and 0xFF reads back 0xFE).
- R2: After reset the prescale register reads 0, the bit clock is 0 and both strobes are 0.
- R3: While running with prescale P and rate R, each level of the bit clock lasts (P/2)×(R+1) peripheral clocks, so one full period lasts P×(R+1) clocks.
- R4: Each bit-clock transition is marked by a strobe in the same cycle as the level change. The rise strobe marks a change from 0 to 1 and the fall strobe a change from 1 to 0. Each strobe is one cycle wide, the two are never high together, and while running they alternate.
- R5: A change of prescale or rate while the clock is running takes effect only when the current full period ends. The half-period in progress and the remaining half keep the old timing.
- R6: When the enable input or the master input is low, the bit clock is driven to the polarity level from the next cycle on, no strobes occur, and the prescale value has no effect.
- R7: The polarity input sets the idle level. Each period starts at that level, so with polarity 1 the first strobe after start is a fall strobe.
- R8: The slave-ratio flag is 1 when the external ratio input is at least 12 and 0 otherwise.
- R9: While the stored prescale is below 2, the generator does not start, produces no strobes, and raises the configuration-error flag whenever the master input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Prescale register write strobe |
| reg_wdata_i | input | 8 | Prescale write data |
| reg_rdata_o | output | 8 | Prescale read data, bit 0 always 0 |
| rate_i | input | 8 | Second-stage rate factor, 0 to 255 |
| enable_i | input | 1 | Generator enable |
| master_i | input | 1 | 1 = master mode, 0 = slave (idle) |
| polarity_i | input | 1 | Idle level of the bit clock |
| ext_ratio_i | input | 8 | Measured peripheral clocks per external bit period |
| bclk_o | output | 1 | Bit-clock level |
| rise_o | output | 1 | One-cycle strobe on a rising bit-clock edge |
| fall_o | output | 1 | One-cycle strobe on a falling bit-clock edge |
| cfg_err_o | output | 1 | Master mode selected with prescale below 2 |
| ext_ok_o | output | 1 | External ratio legal for slave mode |

## Verification
The bench uses the default widths: an 8-bit prescale field, an 8-bit rate and an 8-bit external ratio with a minimum of 12. This keeps every divisor the bench uses within a few dozen cycles. The smallest setting, prescale 2 with rate 0, brings within reach the case where the clock toggles on every cycle and a new configuration is loaded on back-to-back edges. Prescale 4 with rates of 2 and 3 makes the period-boundary reload visible as a measurable difference between the half-period still running and the new full period. The ratio threshold is probed on both sides of 12.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;
    localparam int unsigned PSC_W_DEF     = 8;
    localparam int unsigned RATE_W_DEF    = 8;
    localparam int unsigned EXT_W_DEF     = 8;
    localparam int unsigned MIN_RATIO_DEF = 12;

    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } phase_e;
endpackage

// File: rtl/spi_psc_reg.sv
module spi_psc_reg #(
    parameter int unsigned PSC_W = spi_bclk_pkg::PSC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PSC_W-1:0] wdata_i,
    output logic [PSC_W-1:0] psc_o
);
    logic [PSC_W-1:0] psc_d, psc_q;

    always_comb begin
        psc_d = psc_q;
        if (we_i) begin
            psc_d = {wdata_i[PSC_W-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    assign psc_o = psc_q;
endmodule

// File: rtl/spi_ratio_cmp.sv
module spi_ratio_cmp #(
    parameter int unsigned EXT_W     = spi_bclk_pkg::EXT_W_DEF,
    parameter int unsigned MIN_RATIO = spi_bclk_pkg::MIN_RATIO_DEF
) (
    input  logic [EXT_W-1:0] ratio_i,
    output logic             ok_o
);
    localparam logic [EXT_W-1:0] MIN_VAL = EXT_W'(MIN_RATIO);

    assign ok_o = (ratio_i >= MIN_VAL);
endmodule

// File: rtl/spi_bclk_core.sv
module spi_bclk_core
    import spi_bclk_pkg::*;
#(
    parameter int unsigned PSC_W  = PSC_W_DEF,
    parameter int unsigned RATE_W = RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSC_W-1:0]  psc_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              enable_i,
    input  logic              master_i,
    input  logic              polarity_i,
    output logic              bclk_o,
    output logic              rise_o,
    output logic              fall_o
);
    localparam int unsigned HW = PSC_W - 1;
    localparam logic [PSC_W-1:0] PSC_MIN = PSC_W'(2);

    typedef struct packed {
        logic              run;
        phase_e            ph;
        logic [HW-1:0]     pc;
        logic [RATE_W-1:0] rc;
        logic              bclk;
        logic              rise;
        logic              fall;
        logic [PSC_W-1:0]  apsc;
        logic [RATE_W-1:0] arate;
    } st_t;

    st_t s_d, s_q;
    logic go, usable;
    logic [HW-1:0] half_lim;

    always_comb begin
        go       = enable_i & master_i;
        usable   = (psc_i >= PSC_MIN);
        half_lim = s_q.apsc[PSC_W-1:1] - HW'(1);

        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;

        if (!s_q.run) begin
            s_d.bclk  = polarity_i;
            s_d.pc    = '0;
            s_d.rc    = '0;
            s_d.ph    = PH_LEAD;
            s_d.apsc  = psc_i;
            s_d.arate = rate_i;
            s_d.run   = go & usable;
        end else if (!go) begin
            s_d.run  = 1'b0;
            s_d.bclk = polarity_i;
            s_d.pc   = '0;
            s_d.rc   = '0;
            s_d.ph   = PH_LEAD;
        end else if (s_q.pc != half_lim) begin
            s_d.pc = s_q.pc + HW'(1);
        end else begin
            s_d.pc = '0;
            if (s_q.rc != s_q.arate) begin
                s_d.rc = s_q.rc + RATE_W'(1);
            end else begin
                s_d.rc   = '0;
                s_d.bclk = ~s_q.bclk;
                s_d.rise = ~s_q.bclk;
                s_d.fall = s_q.bclk;
                if (s_q.ph == PH_TRAIL) begin
                    s_d.ph    = PH_LEAD;
                    s_d.apsc  = psc_i;
                    s_d.arate = rate_i;
                    s_d.run   = usable;
                end else begin
                    s_d.ph = PH_TRAIL;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk_o = s_q.bclk;
    assign rise_o = s_q.rise;
    assign fall_o = s_q.fall;
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
    import spi_bclk_pkg::*;
#(
    parameter int unsigned PSC_W     = PSC_W_DEF,
    parameter int unsigned RATE_W    = RATE_W_DEF,
    parameter int unsigned EXT_W     = EXT_W_DEF,
    parameter int unsigned MIN_RATIO = MIN_RATIO_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [PSC_W-1:0]  reg_wdata_i,
    output logic [PSC_W-1:0]  reg_rdata_o,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              enable_i,
    input  logic              master_i,
    input  logic              polarity_i,
    input  logic [EXT_W-1:0]  ext_ratio_i,
    output logic              bclk_o,
    output logic              rise_o,
    output logic              fall_o,
    output logic              cfg_err_o,
    output logic              ext_ok_o
);
    logic [PSC_W-1:0] psc_q;

    spi_psc_reg #(.PSC_W(PSC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .psc_o   (psc_q)
    );

    spi_bclk_core #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_i      (psc_q),
        .rate_i     (rate_i),
        .enable_i   (enable_i),
        .master_i   (master_i),
        .polarity_i (polarity_i),
        .bclk_o     (bclk_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o)
    );

    spi_ratio_cmp #(.EXT_W(EXT_W), .MIN_RATIO(MIN_RATIO)) u_ratio (
        .ratio_i (ext_ratio_i),
        .ok_o    (ext_ok_o)
    );

    assign reg_rdata_o = psc_q;
    assign cfg_err_o   = master_i & (psc_q < PSC_W'(2));
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk #(
    parameter int unsigned PSC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             master_i,
    input logic [PSC_W-1:0] reg_rdata_o,
    input logic             bclk_o,
    input logic             rise_o,
    input logic             fall_o
);
    AST_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[0] == 1'b0); // R1

    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R4

    AST_RISE_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (bclk_o && !$past(bclk_o))); // R4

    AST_FALL_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!bclk_o && $past(bclk_o))); // R4

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_i && master_i) |=> (!rise_o && !fall_o)); // R6
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk #(.PSC_W(PSC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .master_i    (master_i),
    .reg_rdata_o (reg_rdata_o),
    .bclk_o      (bclk_o),
    .rise_o      (rise_o),
    .fall_o      (fall_o)
);

// File: tb/spi_bitclk_gen_test.sv
`timescale 1ns/1ps
module spi_bitclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] rate = '0;
    logic       en = 1'b0;
    logic       master = 1'b0;
    logic       pol = 1'b0;
    logic [7:0] ext = '0;
    logic       bclk, rise, fall, cfg_err, ext_ok;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_bitclk_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .rate_i(rate), .enable_i(en), .master_i(master),
        .polarity_i(pol), .ext_ratio_i(ext), .bclk_o(bclk), .rise_o(rise),
        .fall_o(fall), .cfg_err_o(cfg_err), .ext_ok_o(ext_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference: one flat counter per half period
    int m_psc = 0, m_cnt = 0, m_p = 0, m_r = 0;
    bit m_run = 0, m_phase = 0, m_bclk = 0, m_rise = 0, m_fall = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_psc = 0; m_cnt = 0; m_p = 0; m_r = 0;
            m_run = 0; m_phase = 0; m_bclk = 0; m_rise = 0; m_fall = 0;
        end else begin
            cyc++;
            m_rise = 0;
            m_fall = 0;
            if (!m_run) begin
                m_bclk = pol; m_cnt = 0; m_phase = 0; m_p = m_psc; m_r = int'(rate);
                if (en && master && m_psc >= 2) m_run = 1;
            end else if (!(en && master)) begin
                m_run = 0; m_bclk = pol;
            end else begin
                m_cnt++;
                if (m_cnt == (m_p / 2) * (m_r + 1)) begin
                    m_cnt = 0;
                    m_bclk = !m_bclk;
                    if (m_bclk) m_rise = 1; else m_fall = 1;
                    if (m_phase) begin
                        m_p = m_psc; m_r = int'(rate);
                        if (m_psc < 2) m_run = 0;
                    end
                    m_phase = !m_phase;
                end
            end
            if (we) m_psc = int'(wdata) & 32'hFE;
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bclk == m_bclk, "R3 bclk level", int'(bclk), int'(m_bclk));
            chk(rise == m_rise, "R4 rise strobe", int'(rise), int'(m_rise));
            chk(fall == m_fall, "R4 fall strobe", int'(fall), int'(m_fall));
            chk(int'(rdata) == m_psc, "R1 readback", int'(rdata), m_psc);
            chk(cfg_err == (master && m_psc < 2), "R9 cfg_err", int'(cfg_err), int'(master && m_psc < 2));
            chk(ext_ok == (ext >= 8'd12), "R8 ext_ok", int'(ext_ok), int'(ext >= 8'd12));
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wait_edge(input bit want_rise, output int stamp);
        stamp = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (want_rise ? rise : fall) begin
                stamp = cyc;
                break;
            end
        end
    endtask

    initial begin
        int t0, t1, t2, cnt;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 8'd0, "R2 reset prescale", int'(rdata), 0);
        chk(bclk == 1'b0, "R2 reset bclk", int'(bclk), 0);
        chk(!rise && !fall, "R2 reset strobes", int'({rise, fall}), 0);
        master = 1'b1; #1;
        chk(cfg_err == 1'b1, "R2 cfg_err after reset", int'(cfg_err), 1);

        wr(8'h05); #1;
        chk(rdata == 8'h04, "R1 write 0x05", int'(rdata), 4);
        wr(8'hFF); #1;
        chk(rdata == 8'hFE, "R1 write 0xFF", int'(rdata), 254);
        wr(8'h01); #1;
        chk(rdata == 8'h00, "R1 write 0x01", int'(rdata), 0);

        // R9: unprogrammed prescale, enabled master
        en = 1'b1; rate = 8'd0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (rise || fall) cnt++; end
        chk(cnt == 0, "R9 no strobes at prescale 0", cnt, 0);
        chk(cfg_err == 1'b1, "R9 cfg_err raised", int'(cfg_err), 1);

        // R3: prescale 2, rate 0 -> period 2
        wr(8'd2);
        wait_edge(1'b1, t0); wait_edge(1'b1, t1);
        chk(t1 - t0 == 2, "R3 period psc2 rate0", t1 - t0, 2);

        // R3: prescale 4, rate 2 -> period 12, half 6
        rate = 8'd2; wr(8'd4);
        wait_edge(1'b1, t0); wait_edge(1'b1, t0);
        wait_edge(1'b0, t1); wait_edge(1'b1, t2);
        chk(t1 - t0 == 6, "R3 half period psc4 rate2", t1 - t0, 6);
        chk(t2 - t0 == 12, "R3 period psc4 rate2", t2 - t0, 12);

        // R5: change rate mid-period
        rate = 8'd0;
        wait_edge(1'b1, t0); wait_edge(1'b1, t0);
        @(negedge clk); rate = 8'd3;
        wait_edge(1'b0, t1); wait_edge(1'b0, t2);
        chk(t1 - t0 == 2, "R5 running half keeps old timing", t1 - t0, 2);
        chk(t2 - t1 == 16, "R5 new period after boundary", t2 - t1, 16);

        // R6: disable mid-period while high
        wait_edge(1'b1, t0);
        en = 1'b0;
        @(negedge clk);
        chk(bclk == 1'b0, "R6 idle level after disable", int'(bclk), 0);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (rise || fall) cnt++; end
        chk(cnt == 0, "R6 no strobes while disabled", cnt, 0);

        // R6: slave mode ignores prescale
        master = 1'b0; en = 1'b1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (rise || fall) cnt++; end
        chk(cnt == 0, "R6 slave mode idle", cnt, 0);
        chk(cfg_err == 1'b0, "R6 slave cfg_err low", int'(cfg_err), 0);

        // R7: polarity 1
        en = 1'b0; pol = 1'b1; master = 1'b1; rate = 8'd1;
        step(2);
        chk(bclk == 1'b1, "R7 idle high", int'(bclk), 1);
        en = 1'b1;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rise) begin cnt = 1; break; end
            if (fall) begin cnt = 2; break; end
        end
        chk(cnt == 2, "R7 first strobe is fall", cnt, 2);
        step(30);

        // R9: clearing prescale stops the clock at the period end
        wr(8'd0);
        step(20);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (rise || fall) cnt++; end
        chk(cnt == 0, "R9 clock stops after prescale cleared", cnt, 0);
        chk(bclk == 1'b1, "R9 parked at idle", int'(bclk), 1);

        // R8: external ratio threshold
        ext = 8'd11; #1;
        chk(ext_ok == 1'b0, "R8 ratio 11", int'(ext_ok), 0);
        ext = 8'd12; #1;
        chk(ext_ok == 1'b1, "R8 ratio 12", int'(ext_ok), 1);
        ext = 8'd200; #1;
        chk(ext_ok == 1'b1, "R8 ratio 200", int'(ext_ok), 1);
        step(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule